// File: doc/BRIEF.md
# I2C Byte Transmit Master

This block is a transmit-only I2C bus master. It pulls the open-drain clock and data lines low through two drive-low outputs and reads the data line back through one input. The host first places the target address in the shift register, with the address in bits [7:1] and bit 0 cleared to mark a write. A start command then produces a START condition and clocks that byte onto the bus with no further host action. After each byte the block parks with the clock held low. Every later data-byte write in that parked state sends one complete byte at once.

Each byte is sent most significant bit first. A mode input selects whether a ninth clock is issued, during which the block releases the data line and samples the slave's acknowledge. A stop request can be armed at any point in a session. Once armed, the block ends the session with a STOP condition as soon as the current byte is finished, or at once if the bus is already parked. It does this whether the slave acknowledged or not.

A system-clock-frequency parameter sets a quarter-period divider. Every SCL period is made of four equal quarters. One select input picks between a standard bit rate and a fast bit rate, each set by a parameter.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, and whenever the block is idle, both drive-low outputs are 0, so both lines float high. `busy`, `byte_done` and `nack` are also 0 after reset.
- R2: A `start_cmd` pulse in idle with `en`=1 makes SDA fall while SCL is high. The preloaded byte is then sent MSB first, and a slave sees exactly that byte.
- R3: While parked between bytes, a `load_valid` pulse sends `load_data` right away, MSB first, with no other command.
- R4: With `ack_mode`=1, each byte gets 9 SCL pulses and SDA is released during the ninth. With `ack_mode`=0, each byte gets exactly 8 pulses.
- R5: In every bit, SCL stays high for 2 quarters. One quarter is CLK_HZ/(4*rate) system cycles. `fast_mode`=1 selects RATE_FAST_HZ and `fast_mode`=0 selects RATE_STD_HZ.
- R6: Within a byte, SDA changes only while SCL is low.
- R7: `nack` holds the SDA level sampled in the high phase of the ninth clock, where 1 means no acknowledge. It is cleared whenever a byte is launched, and it stays 0 when `ack_mode`=0.
- R8: A `stop_arm` pulse during a byte causes a STOP right after that byte, whether the slave acknowledged or not. A STOP is SDA rising while SCL is high. A `stop_arm` pulse while parked causes a STOP at once. Without an armed stop, the bus stays parked with SCL low and no STOP. After the STOP the block returns to idle.
- R9: `busy` is 1 from START through the end of each byte and during STOP. It is 0 while parked and while idle. `byte_done` is a single-cycle pulse at the end of every byte.
- R10: A `load_valid` or `start_cmd` pulse while `busy`=1 has no effect on the byte on the wire. A `start_cmd` pulse while `en`=0 produces no START.
- R11: Dropping `en` releases both lines and clears `busy` by the next clock edge, aborting any byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low forces idle |
| fast_mode | input | 1 | 1 selects fast bit rate, 0 standard |
| ack_mode | input | 1 | 1 adds the ninth acknowledge clock |
| start_cmd | input | 1 | Pulse: START and send the preloaded byte |
| load_valid | input | 1 | Pulse: write `load_data` to the shift register |
| load_data | input | 8 | Byte to send (first byte: address in [7:1], 0 in [0]) |
| stop_arm | input | 1 | Pulse: arm a STOP for the end of the session |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Bus activity in progress |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| nack | output | 1 | Last acknowledge sample, 1 = not acknowledged |

## Verification
The bench builds the block with CLK_HZ set to 3,200,000. This gives quarters of 8 cycles at the standard rate and 2 cycles at the fast rate, so both rates can be checked exactly: the fast rate sits at the 2-cycle floor where the sampling and hold paths are tightest, and the standard rate completes bytes in a few hundred cycles. A bench slave decodes the wired lines, answers the ninth clock with a randomly chosen ACK or NACK, and measures every high phase of SCL against the rate chosen.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_HOLD,
        ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        QTR_0,
        QTR_1,
        QTR_2,
        QTR_3
    } quarter_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    // System cycles per quarter of an SCL period, never below two.
    function automatic int unsigned quarter_cycles(int unsigned clk_hz, int unsigned rate_hz);
        int unsigned q;
        q = clk_hz / (4 * rate_hz);
        return (q < 2) ? 2 : q;
    endfunction

    function automatic quarter_e quarter_inc(quarter_e q);
        return quarter_e'(q + 2'd1);
    endfunction

endpackage

// File: rtl/i2c_tx_qtick.sv
module i2c_tx_qtick #(
    parameter int unsigned QSTD  = 125,
    parameter int unsigned QFAST = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int unsigned QMAX = (QSTD > QFAST) ? QSTD : QFAST;
    localparam int CW = $clog2(QMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    assign reload = fast ? CW'(QFAST - 1) : CW'(QSTD - 1);
    assign tick   = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= reload;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5

endmodule

// File: rtl/i2c_tx_shreg.sv
module i2c_tx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] data;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load) begin
            data <= din;
        end else if (shift) begin
            data <= {data[W-2:0], 1'b0};
        end
    end

    assign msb = data[W-1];

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && shift)); // R3

endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
    import i2c_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        start_cmd,
    input  logic        load_valid,
    input  logic        stop_arm,
    input  logic        ack_mode,
    input  logic        fast_mode,
    input  logic        sda_sample,
    input  logic        tick,
    input  logic        msb,
    output logic        run,
    output logic        fast_sel,
    output logic        load_go,
    output logic        shift_go,
    output line_drive_t drive,
    output logic        in_bit,
    output logic        busy,
    output logic        byte_done,
    output logic        nack
);
    localparam int IDXW = $clog2(BYTE_W + 1);
    localparam logic [IDXW-1:0] ACK_IDX   = IDXW'(BYTE_W);
    localparam logic [IDXW-1:0] LAST_DATA = IDXW'(BYTE_W - 1);

    seq_state_e      state;
    quarter_e        qtr;
    logic [IDXW-1:0] bitidx;
    logic            stop_armed;
    logic            ack_lat;
    logic            fast_lat;
    logic            nack_q;
    logic            done_q;
    logic            sda_last;
    logic [IDXW-1:0] last_idx;
    logic            stop_due;

    assign last_idx  = ack_lat ? ACK_IDX : LAST_DATA;
    assign stop_due  = stop_armed || stop_arm;
    assign run       = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
    assign busy      = run;
    assign in_bit    = (state == ST_BIT);
    assign fast_sel  = fast_lat;
    assign byte_done = done_q;
    assign nack      = nack_q;

    assign load_go  = en && load_valid &&
                      ((state == ST_IDLE) || ((state == ST_HOLD) && !stop_due));
    assign shift_go = tick && (state == ST_BIT) && (qtr == QTR_3) && (bitidx != last_idx);

    // Line levels for the current quarter; quarter 0 of a bit holds the previous SDA.
    always_comb begin
        drive = '0;
        unique case (state)
            ST_IDLE: drive = '0;
            ST_START: begin
                drive.scl_low = 1'b0;
                drive.sda_low = (qtr == QTR_2) || (qtr == QTR_3);
            end
            ST_BIT: begin
                drive.scl_low = (qtr == QTR_0) || (qtr == QTR_1);
                if (qtr == QTR_0)
                    drive.sda_low = sda_last;
                else if (bitidx == ACK_IDX)
                    drive.sda_low = 1'b0;
                else
                    drive.sda_low = !msb;
            end
            ST_HOLD: begin
                drive.scl_low = 1'b1;
                drive.sda_low = sda_last;
            end
            ST_STOP: begin
                drive.scl_low = (qtr == QTR_0) || (qtr == QTR_1);
                drive.sda_low = (qtr == QTR_0) ? sda_last : (qtr != QTR_3);
            end
            default: drive = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            qtr        <= QTR_0;
            bitidx     <= '0;
            stop_armed <= 1'b0;
            ack_lat    <= 1'b0;
            fast_lat   <= 1'b0;
            nack_q     <= 1'b0;
            done_q     <= 1'b0;
            sda_last   <= 1'b0;
        end else if (!en) begin
            state      <= ST_IDLE;
            qtr        <= QTR_0;
            bitidx     <= '0;
            stop_armed <= 1'b0;
            done_q     <= 1'b0;
            sda_last   <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            sda_last <= drive.sda_low;
            if (stop_arm && (state != ST_IDLE))
                stop_armed <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start_cmd) begin
                        state      <= ST_START;
                        qtr        <= QTR_0;
                        ack_lat    <= ack_mode;
                        fast_lat   <= fast_mode;
                        nack_q     <= 1'b0;
                        stop_armed <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (qtr == QTR_3) begin
                            state  <= ST_BIT;
                            qtr    <= QTR_0;
                            bitidx <= '0;
                        end else begin
                            qtr <= quarter_inc(qtr);
                        end
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        if ((qtr == QTR_2) && (bitidx == ACK_IDX))
                            nack_q <= sda_sample;
                        if (qtr == QTR_3) begin
                            qtr <= QTR_0;
                            if (bitidx == last_idx) begin
                                done_q <= 1'b1;
                                state  <= stop_due ? ST_STOP : ST_HOLD;
                            end else begin
                                bitidx <= bitidx + 1'b1;
                            end
                        end else begin
                            qtr <= quarter_inc(qtr);
                        end
                    end
                end
                ST_HOLD: begin
                    if (stop_due) begin
                        state <= ST_STOP;
                        qtr   <= QTR_0;
                    end else if (load_valid) begin
                        state    <= ST_BIT;
                        qtr      <= QTR_0;
                        bitidx   <= '0;
                        ack_lat  <= ack_mode;
                        fast_lat <= fast_mode;
                        nack_q   <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (qtr == QTR_3) begin
                            state      <= ST_IDLE;
                            qtr        <= QTR_0;
                            stop_armed <= 1'b0;
                        end else begin
                            qtr <= quarter_inc(qtr);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R9

    AST_NACK_HELD_PARKED: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD) && $past(state == ST_HOLD)) |-> $stable(nack_q)); // R7

    AST_BITIDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bitidx <= ACK_IDX); // R4

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(state == ST_STOP) && $past(en) && (state != ST_STOP)) |-> (state == ST_IDLE)); // R8

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
    import i2c_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned RATE_STD_HZ  = 100_000,
    parameter int unsigned RATE_FAST_HZ = 400_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        fast_mode,
    input  logic        ack_mode,
    input  logic        start_cmd,
    input  logic        load_valid,
    input  logic [7:0]  load_data,
    input  logic        stop_arm,
    input  logic        sda_in,
    output logic        scl_drive_low,
    output logic        sda_drive_low,
    output logic        busy,
    output logic        byte_done,
    output logic        nack
);
    localparam int unsigned QSTD  = quarter_cycles(CLK_HZ, RATE_STD_HZ);
    localparam int unsigned QFAST = quarter_cycles(CLK_HZ, RATE_FAST_HZ);

    logic        run;
    logic        fast_sel;
    logic        tick;
    logic        load_go;
    logic        shift_go;
    logic        msb;
    logic        in_bit;
    logic        in_bit_q;
    logic [1:0]  sda_sync;
    line_drive_t drive;
    line_drive_t pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_sync <= 2'b11;
        end else begin
            sda_sync <= {sda_sync[0], sda_in};
        end
    end

    i2c_tx_qtick #(
        .QSTD (QSTD),
        .QFAST(QFAST)
    ) u_qtick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .fast(fast_sel),
        .tick(tick)
    );

    i2c_tx_shreg #(
        .W(BYTE_W)
    ) u_shreg (
        .clk  (clk),
        .rst  (rst),
        .load (load_go),
        .din  (load_data),
        .shift(shift_go),
        .msb  (msb)
    );

    i2c_tx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start_cmd (start_cmd),
        .load_valid(load_valid),
        .stop_arm  (stop_arm),
        .ack_mode  (ack_mode),
        .fast_mode (fast_mode),
        .sda_sample(sda_sync[1]),
        .tick      (tick),
        .msb       (msb),
        .run       (run),
        .fast_sel  (fast_sel),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .drive     (drive),
        .in_bit    (in_bit),
        .busy      (busy),
        .byte_done (byte_done),
        .nack      (nack)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pin_q    <= '0;
            in_bit_q <= 1'b0;
        end else begin
            pin_q    <= drive;
            in_bit_q <= in_bit;
        end
    end

    assign scl_drive_low = pin_q.scl_low;
    assign sda_drive_low = pin_q.sda_low;

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!pin_q.scl_low && !$past(pin_q.scl_low) && in_bit_q && $past(in_bit_q))
            |-> $stable(pin_q.sda_low)); // R6

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !sda_drive_low && !busy)); // R11

endmodule

// File: tb/i2c_tx_master_test.sv
module i2c_tx_master_test;
    localparam int unsigned CLK_HZ = 3_200_000;
    localparam int unsigned STD_HZ = 100_000;
    localparam int unsigned FST_HZ = 400_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, fast_mode = 1'b0, ack_mode = 1'b1;
    logic start_cmd = 1'b0, load_valid = 1'b0, stop_arm = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic scl_drive_low, sda_drive_low, busy, byte_done, nack;
    logic slave_low = 1'b0;
    logic sda_bus, scl_bus;

    assign scl_bus = !scl_drive_low;
    assign sda_bus = !sda_drive_low && !slave_low;

    always #4 clk = !clk;

    i2c_tx_master #(.CLK_HZ(CLK_HZ), .RATE_STD_HZ(STD_HZ), .RATE_FAST_HZ(FST_HZ)) uut (
        .clk(clk), .rst(rst), .en(en), .fast_mode(fast_mode), .ack_mode(ack_mode),
        .start_cmd(start_cmd), .load_valid(load_valid), .load_data(load_data),
        .stop_arm(stop_arm), .sda_in(sda_bus), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .busy(busy), .byte_done(byte_done), .nack(nack));

    int checks = 0, failures = 0;
    int starts = 0, stops = 0, rx_n = 0, hi_bad = 0, bitcnt = 0, hi_len = 0;
    logic [7:0] rxsh = 8'h00;
    logic [7:0] rx_hist [0:63];
    int clk_hist [0:63];
    logic tb_fast = 1'b0, tb_ack = 1'b1, tb_want_nack = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    function automatic int qlen(logic f);
        int q;
        q = int'(CLK_HZ / (4 * (f ? FST_HZ : STD_HZ)));
        return (q < 2) ? 2 : q;
    endfunction
    function automatic int exp_clocks(logic a);
        return a ? 9 : 8;
    endfunction
    function automatic logic exp_nack(logic a, logic want);
        return a && want;
    endfunction

    // Bus slave and monitor, sampled away from the active edge.
    always @(negedge clk) begin
        logic cur_sda;
        cur_sda = !sda_drive_low && !slave_low;
        if (rst) begin
            bitcnt = 0; hi_len = 0; slave_low = 1'b0;
        end else begin
            if (prev_scl && scl_bus && prev_sda && !cur_sda) begin
                starts++; bitcnt = 0;
            end else if (prev_scl && scl_bus && !prev_sda && cur_sda) begin
                stops++;
            end
            if (!prev_scl && scl_bus) begin
                hi_len = 1;
                if (bitcnt < 8) rxsh = {rxsh[6:0], cur_sda};
                if (bitcnt < 20) bitcnt++;
            end else if (scl_bus) begin
                hi_len++;
            end
            if (prev_scl && !scl_bus) begin
                if (bitcnt >= 1 && hi_len != 2 * qlen(tb_fast)) hi_bad++;
                if (tb_ack && bitcnt == 8) begin
                    slave_low = !tb_want_nack;
                end else if (bitcnt == exp_clocks(tb_ack)) begin
                    rx_hist[rx_n % 64] = rxsh;
                    clk_hist[rx_n % 64] = bitcnt;
                    rx_n++; bitcnt = 0; slave_low = 1'b0;
                end
            end
        end
        prev_scl = scl_bus;
        prev_sda = cur_sda;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_load(input logic [7:0] d);
        @(negedge clk); load_data = d; load_valid = 1'b1;
        @(negedge clk); load_valid = 1'b0;
    endtask
    task automatic pulse_start();
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_arm = 1'b1;
        @(negedge clk); stop_arm = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        for (k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (byte_done) break;
        end
        check({req, " byte_done timeout"}, int'(k < 20000), 1);
        cycles(4);
    endtask

    task automatic wait_idle();
        int k;
        for (k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        cycles(3);
    endtask

    task automatic run_txn(input logic f, input logic a, input int nb);
        int s0, p0, hb0;
        fast_mode = f; ack_mode = a; tb_fast = f; tb_ack = a;
        s0 = starts; p0 = stops; hb0 = hi_bad;
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            int n0;
            b = (i == 0) ? {7'($urandom), 1'b0} : 8'($urandom);
            tb_want_nack = 1'($urandom);
            n0 = rx_n;
            pulse_load(b);
            if (i == 0) pulse_start();
            if (i == nb - 1) begin cycles(5); pulse_stop(); end
            wait_done(i == 0 ? "R2" : "R3");
            check(i == 0 ? "R2 byte count" : "R3 byte count", rx_n, n0 + 1);
            check(i == 0 ? "R2 byte value" : "R3 byte value", int'(rx_hist[n0 % 64]), int'(b));
            check("R4 clocks per byte", clk_hist[n0 % 64], exp_clocks(a));
            check("R7 nack flag", int'(nack), int'(exp_nack(a, tb_want_nack)));
            if (i < nb - 1) begin
                check("R9 busy low when parked", int'(busy), 0);
                check("R8 SCL held low when parked", int'(scl_drive_low), 1);
            end
        end
        wait_idle();
        check("R8 one STOP after session", stops, p0 + 1);
        check("R2 one START per session", starts, s0 + 1);
        check("R5 SCL high time", hi_bad, hb0);
        check("R1 lines released in idle", int'(scl_drive_low || sda_drive_low), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int s0, p0, n0;
        void'($urandom(32'h1c2d));
        cycles(3);
        rst = 1'b0;
        cycles(2);
        // R1 reset state
        check("R1 scl after reset", int'(scl_drive_low), 0);
        check("R1 sda after reset", int'(sda_drive_low), 0);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 nack after reset", int'(nack), 0);
        check("R1 byte_done after reset", int'(byte_done), 0);
        en = 1'b1;
        cycles(3);
        check("R1 SCL high when idle and enabled", int'(scl_drive_low), 0);

        // Directed: both rates, both ack modes, NACK with armed stop.
        run_txn(1'b0, 1'b1, 2);
        run_txn(1'b1, 1'b1, 2);
        run_txn(1'b0, 1'b0, 2);
        run_txn(1'b1, 1'b0, 1);

        // R10: load and start during a byte are ignored.
        fast_mode = 1'b0; ack_mode = 1'b1; tb_fast = 1'b0; tb_ack = 1'b1; tb_want_nack = 1'b0;
        s0 = starts; p0 = stops; n0 = rx_n;
        pulse_load(8'hA4);
        pulse_start();
        cycles(40);
        check("R9 busy during byte", int'(busy), 1);
        pulse_load(8'h5B);
        pulse_start();
        wait_done("R10");
        check("R10 byte unaffected by load while busy", int'(rx_hist[n0 % 64]), 8'hA4);
        check("R10 no extra START", starts, s0 + 1);
        // R8: parked without arm stays parked, arm then stops at once.
        cycles(30);
        check("R8 no STOP without arm", stops, p0);
        check("R8 SCL low while parked", int'(scl_drive_low), 1);
        pulse_stop();
        wait_idle();
        check("R8 STOP after arm in parked state", stops, p0 + 1);
        check("R9 busy low after STOP", int'(busy), 0);

        // R11: drop enable mid byte.
        pulse_load(8'h3C);
        pulse_start();
        cycles(60);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check("R11 lines released after disable", int'(scl_drive_low || sda_drive_low), 0);
        check("R11 busy cleared after disable", int'(busy), 0);
        s0 = starts;
        pulse_start();
        cycles(50);
        check("R10 start ignored while disabled", starts, s0);
        check("R10 still idle while disabled", int'(busy), 0);
        en = 1'b1;
        cycles(5);

        // Constrained random sessions.
        for (int t = 0; t < 8; t++) begin
            run_txn(1'($urandom), 1'($urandom), 1 + int'($urandom % 3));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule